// File: doc/BRIEF.md
# Bus-Controller Reply Validator

This block judges the reply a remote terminal returns to one bus-controller message on a 1553 serial data bus. The message sequencer pulses `start` when its last command or data word has left the transmitter and presents the per-message settings on the `cfg_*` inputs. The block then times the silence before the reply with one of four programmable limits. It takes the word stream from an upstream decoder, which supplies a sync-type bit, 16 data bits, a parity bit and two error strobes for each word. Every word is checked for its position and its coding, and the block counts the words. It compares the terminal address in each returned status word with the expected one. Status bits that the message has not masked are treated as failures.

The reply is taken as complete when the word stream has stayed quiet for a fixed gap. The block then gives a one-cycle `done` strobe, a `pass` level and an error-flag vector that holds until the next `start`. On a failure it either asks for a retry, optionally on the other bus channel, or reports a final failure once the retry budget for the message is spent. A `start` that follows a retry request is taken to be that retry. Any other `start` begins a fresh message. A `start` in the middle of a reply abandons it.

Top module: `bc_reply_check`

## Requirements
- R1: While reset is held and after it is released, `done`, `pass`, `err_flags`, `retry_req`, `final_fail` and `retry_bus` are all 0.
- R2: `cfg_tmo_sel` values 0, 1, 2 and 3 select reply limits of 18, 22, 50 and 130 microseconds. If no word arrives within the selected limit after `start`, `done` pulses with `err_flags` equal to only bit 0 (timeout). A first word that arrives before the limit prevents the timeout.
- R3: `start` clears `err_flags` and `pass` in the cycle after it, whatever their previous value.
- R4: Word position 0 must carry status sync (`rx_stat_sync`=1) and positions 1 to N must carry data sync (`rx_stat_sync`=0), where N is `cfg_data_words`. A mismatch sets bit 1 (sync).
- R5: A word with `rx_enc_err`=1 sets bit 2 (encoding).
- R6: A word whose 16 data bits plus `rx_par` do not hold an odd number of ones sets bit 3 (parity). A word with `rx_len_err`=1 sets bit 4 (bit count).
- R7: Without a terminal-to-terminal transfer, a reply of any total other than N+1 words sets bit 5 (word count). Words after position N+1 are counted but not sync-checked.
- R8: If status word bits 15..11 at position 0 differ from `cfg_rt_addr`, bit 6 (address) is set.
- R9: If status bits 10..0 are set in a status word where the matching bit of `cfg_stat_mask` is 0, bit 8 (status) is set. A mask bit of 1 makes the status bit harmless.
- R10: With `cfg_rt2rt`=1, position N+1 must be a second status word. It must carry status sync and the address `cfg_rt_addr2`, otherwise bit 7 (terminal-to-terminal) is set. A total of exactly N+1 words sets only bit 7. A total below N+1 sets bits 5 and 7. A total above N+2 sets bit 5.
- R11: A failing reply with `cfg_retry_en`=1 and retries left raises `retry_req` with `done`. `retry_bus` becomes `cfg_cur_bus` XOR `cfg_bus_switch`.
- R12: After MAX_RETRY consecutive retries of one message, or with retries disabled, a failing reply raises `final_fail` with `done` instead of `retry_req`. A passing reply or a fresh message restores the full budget.
- R13: `done` is high for exactly one cycle per reply, and `pass` stays high until the next `start` when all flags are 0. Words that arrive while no reply is awaited change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Last word sent; begins timing the reply |
| cfg_tmo_sel | input | 2 | Reply-limit select code |
| cfg_data_words | input | 6 | Data words the command implies (0 to 32) |
| cfg_rt_addr | input | 5 | Expected address in the first status word |
| cfg_rt2rt | input | 1 | Terminal-to-terminal transfer: expect a second status word |
| cfg_rt_addr2 | input | 5 | Expected address in the second status word |
| cfg_stat_mask | input | 11 | 1 = ignore that status bit |
| cfg_retry_en | input | 1 | Retries allowed for this message |
| cfg_bus_switch | input | 1 | Retry on the other channel |
| cfg_cur_bus | input | 1 | Channel used for this attempt |
| rx_valid | input | 1 | Decoded word strobe |
| rx_stat_sync | input | 1 | 1 = status/command sync, 0 = data sync |
| rx_word | input | 16 | Decoded data bits |
| rx_par | input | 1 | Received parity bit |
| rx_enc_err | input | 1 | Decoder saw bad bit coding |
| rx_len_err | input | 1 | Decoder saw a wrong bit count |
| done | output | 1 | One-cycle verdict strobe |
| pass | output | 1 | Reply valid, held until next start |
| err_flags | output | 9 | Sticky error flags, bit 0 timeout to bit 8 status |
| retry_req | output | 1 | Retry requested (with done) |
| retry_bus | output | 1 | Channel for the retry, held |
| final_fail | output | 1 | Failure with no retry left (with done) |

## Verification
A wrong position counter shows up at the ports as a spurious sync, word-count or terminal-to-terminal flag on the `done` of that same reply. This makes the tables of short, over-long and missing-status replies the quickest way to expose it. A prescaler or limit-select fault moves the timeout `done` by whole microseconds and is caught by measuring cycles from `start` to `done` for each select code. A stuck attempt counter passes the first retry. It surfaces only on the third consecutive failure, when `final_fail` and `retry_req` swap, or on the next fresh message. For that reason the retry sequence runs failure chains of full length and then restarts the budget.

// File: rtl/bcr_pkg.sv
// Shared definitions for the bus-controller reply validator.
// Assumes: flag positions are fixed and decoded by the message sequencer.
package bcr_pkg;
    localparam int NFLAG  = 9;
    localparam int F_TMO  = 0;
    localparam int F_SYNC = 1;
    localparam int F_ENC  = 2;
    localparam int F_PAR  = 3;
    localparam int F_LEN  = 4;
    localparam int F_WC   = 5;
    localparam int F_ADDR = 6;
    localparam int F_R2R  = 7;
    localparam int F_STAT = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RECV = 2'd2
    } state_t;
endpackage

// File: rtl/bcr_us_tick.sv
// Microsecond tick prescaler: pulses tick once every CLK_PER_US cycles.
// Assumes: CLK_PER_US >= 2; clr realigns the phase so timing starts at start.
module bcr_us_tick #(
    parameter int CLK_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = $clog2(CLK_PER_US);
    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(CLK_PER_US - 1));

    // Divide the clock down to one pulse per microsecond.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/bcr_word_check.sv
// Per-word checker: classifies one decoded word by its reply position and
// returns the error flags it raises. Purely combinational.
// Assumes: pos counts words already accepted in this reply (0 = first).
module bcr_word_check
    import bcr_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] n_words,
    input  logic             rt2rt,
    input  logic [4:0]       addr1,
    input  logic [4:0]       addr2,
    input  logic [10:0]      mask,
    input  logic             stat_sync,
    input  logic [15:0]      word,
    input  logic             par,
    input  logic             enc_err,
    input  logic             len_err,
    output logic [NFLAG-1:0] err
);
    logic        is_s1, is_dat, is_s2;
    logic [10:0] live_bits;

    assign is_s1     = (pos == '0);
    assign is_dat    = (pos != '0) && (pos <= n_words);
    assign is_s2     = rt2rt && (pos == n_words + POS_W'(1));
    assign live_bits = word[10:0] & ~mask;

    // Raise the coding flags for every word and the position flags by role.
    always_comb begin
        err         = '0;
        err[F_PAR]  = ~(^{word, par});
        err[F_ENC]  = enc_err;
        err[F_LEN]  = len_err;
        if (is_s1) begin
            err[F_SYNC] = ~stat_sync;
            err[F_ADDR] = (word[15:11] != addr1);
            err[F_STAT] = |live_bits;
        end else if (is_dat) begin
            err[F_SYNC] = stat_sync;
        end else if (is_s2) begin
            err[F_R2R]  = ~stat_sync || (word[15:11] != addr2);
            err[F_STAT] = |live_bits;
        end
    end
endmodule

// File: rtl/bcr_retry.sv
// Retry tracker: counts consecutive retries of one message and converts a
// failing verdict into a retry request or a final failure.
// Assumes: a start that follows a retry request is that retry.
module bcr_retry #(
    parameter int MAX_RETRY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic finish,
    input  logic fail,
    input  logic retry_en,
    input  logic bus_switch,
    input  logic cur_bus,
    output logic retry_req,
    output logic final_fail,
    output logic retry_bus
);
    localparam int AW = $clog2(MAX_RETRY + 2);
    logic [AW-1:0] attempts;
    logic          pend;
    logic          left;

    assign left = (attempts < AW'(MAX_RETRY));

    // Track the retry budget and issue one verdict pulse per finished reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attempts   <= '0;
            pend       <= 1'b0;
            retry_req  <= 1'b0;
            final_fail <= 1'b0;
            retry_bus  <= 1'b0;
        end else begin
            retry_req  <= 1'b0;
            final_fail <= 1'b0;
            if (start) begin
                attempts <= pend ? attempts + 1'b1 : '0;
                pend     <= 1'b0;
            end else if (finish) begin
                if (fail && retry_en && left) begin
                    retry_req <= 1'b1;
                    pend      <= 1'b1;
                    retry_bus <= cur_bus ^ bus_switch;
                end else begin
                    final_fail <= fail;
                    pend       <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/bc_reply_check.sv
// Reply validator top: times the reply gap, accumulates per-word errors,
// decides the end of the reply after a quiet gap and issues the verdict.
// Assumes: TO3_US is the largest limit and GAP_US does not exceed it;
// configuration is sampled at start and held internally for the reply.
module bc_reply_check
    import bcr_pkg::*;
#(
    parameter int CLK_PER_US = 125,
    parameter int TO0_US     = 18,
    parameter int TO1_US     = 22,
    parameter int TO2_US     = 50,
    parameter int TO3_US     = 130,
    parameter int GAP_US     = 24,
    parameter int MAX_WORDS  = 32,
    parameter int MAX_RETRY  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [1:0]                 cfg_tmo_sel,
    input  logic [$clog2(MAX_WORDS+1)-1:0] cfg_data_words,
    input  logic [4:0]                 cfg_rt_addr,
    input  logic                       cfg_rt2rt,
    input  logic [4:0]                 cfg_rt_addr2,
    input  logic [10:0]                cfg_stat_mask,
    input  logic                       cfg_retry_en,
    input  logic                       cfg_bus_switch,
    input  logic                       cfg_cur_bus,
    input  logic                       rx_valid,
    input  logic                       rx_stat_sync,
    input  logic [15:0]                rx_word,
    input  logic                       rx_par,
    input  logic                       rx_enc_err,
    input  logic                       rx_len_err,
    output logic                       done,
    output logic                       pass,
    output logic [NFLAG-1:0]           err_flags,
    output logic                       retry_req,
    output logic                       retry_bus,
    output logic                       final_fail
);
    localparam int WC_W  = $clog2(MAX_WORDS + 1);
    localparam int POS_W = $clog2(MAX_WORDS + 4);
    localparam int US_W  = $clog2(TO3_US + 1);

    state_t           state;
    logic [US_W-1:0]  us_cnt;
    logic [US_W-1:0]  lim;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] n_q;
    logic [WC_W-1:0]  nw_q;
    logic [1:0]       tsel_q;
    logic             rt2rt_q, retry_en_q, switch_q, bus_q;
    logic [4:0]       addr1_q, addr2_q;
    logic [10:0]      mask_q;
    logic [NFLAG-1:0] word_err, end_err, fin_flags;
    logic             tick, fin_tmo, fin_gap, finish;

    assign n_q = POS_W'(nw_q);

    bcr_us_tick #(.CLK_PER_US(CLK_PER_US)) i_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .tick  (tick)
    );

    bcr_word_check #(.POS_W(POS_W)) i_word (
        .pos       (pos),
        .n_words   (n_q),
        .rt2rt     (rt2rt_q),
        .addr1     (addr1_q),
        .addr2     (addr2_q),
        .mask      (mask_q),
        .stat_sync (rx_stat_sync),
        .word      (rx_word),
        .par       (rx_par),
        .enc_err   (rx_enc_err),
        .len_err   (rx_len_err),
        .err       (word_err)
    );

    // Pick the reply limit for this message.
    always_comb begin
        case (tsel_q)
            2'd0:    lim = US_W'(TO0_US);
            2'd1:    lim = US_W'(TO1_US);
            2'd2:    lim = US_W'(TO2_US);
            default: lim = US_W'(TO3_US);
        endcase
    end

    // Judge the word total once the reply has gone quiet.
    always_comb begin
        end_err = '0;
        if (!rt2rt_q) begin
            end_err[F_WC] = (pos != n_q + POS_W'(1));
        end else if (pos < n_q + POS_W'(1)) begin
            end_err[F_WC]  = 1'b1;
            end_err[F_R2R] = 1'b1;
        end else if (pos == n_q + POS_W'(1)) begin
            end_err[F_R2R] = 1'b1;
        end else if (pos > n_q + POS_W'(2)) begin
            end_err[F_WC]  = 1'b1;
        end
    end

    // Detect the two ways a reply ends and form its final flags.
    always_comb begin
        fin_tmo = !start && (state == ST_WAIT) && !rx_valid && tick
                  && (us_cnt == lim - US_W'(1));
        fin_gap = !start && (state == ST_RECV) && !rx_valid && tick
                  && (us_cnt == US_W'(GAP_US - 1));
        finish  = fin_tmo || fin_gap;
        fin_flags = err_flags;
        if (fin_tmo) fin_flags[F_TMO] = 1'b1;
        if (fin_gap) fin_flags = err_flags | end_err;
    end

    // Reply sequencer: latch settings, gather flags, issue the verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            us_cnt     <= '0;
            pos        <= '0;
            nw_q       <= '0;
            tsel_q     <= '0;
            rt2rt_q    <= 1'b0;
            retry_en_q <= 1'b0;
            switch_q   <= 1'b0;
            bus_q      <= 1'b0;
            addr1_q    <= '0;
            addr2_q    <= '0;
            mask_q     <= '0;
            err_flags  <= '0;
            pass       <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                state      <= ST_WAIT;
                us_cnt     <= '0;
                pos        <= '0;
                nw_q       <= cfg_data_words;
                tsel_q     <= cfg_tmo_sel;
                rt2rt_q    <= cfg_rt2rt;
                retry_en_q <= cfg_retry_en;
                switch_q   <= cfg_bus_switch;
                bus_q      <= cfg_cur_bus;
                addr1_q    <= cfg_rt_addr;
                addr2_q    <= cfg_rt_addr2;
                mask_q     <= cfg_stat_mask;
                err_flags  <= '0;
                pass       <= 1'b0;
            end else if (finish) begin
                state     <= ST_IDLE;
                err_flags <= fin_flags;
                pass      <= (fin_flags == '0);
                done      <= 1'b1;
            end else if (state != ST_IDLE && rx_valid) begin
                state     <= ST_RECV;
                err_flags <= err_flags | word_err;
                us_cnt    <= '0;
                if (pos != '1) pos <= pos + POS_W'(1);
            end else if (state != ST_IDLE && tick) begin
                us_cnt <= us_cnt + US_W'(1);
            end
        end
    end

    bcr_retry #(.MAX_RETRY(MAX_RETRY)) i_retry (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .finish     (finish),
        .fail       (fin_flags != '0),
        .retry_en   (retry_en_q),
        .bus_switch (switch_q),
        .cur_bus    (bus_q),
        .retry_req  (retry_req),
        .final_fail (final_fail),
        .retry_bus  (retry_bus)
    );
endmodule

// File: rtl/bcr_checker.sv
// Property checker for the reply validator, attached by bind.
// Assumes: observes only the top-level ports.
module bcr_checker
    import bcr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic             pass,
    input logic [NFLAG-1:0] err_flags,
    input logic             retry_req,
    input logic             final_fail
);
    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_pass_clean_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (done && pass) |-> (err_flags == '0 && !retry_req && !final_fail));

    assert_clear_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (err_flags == '0 && !pass));

    assert_timeout_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err_flags[F_TMO] |-> (err_flags == NFLAG'(1)));

    assert_retry_on_fail_R11: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |-> (done && err_flags != '0));

    assert_verdict_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(retry_req && final_fail));

    assert_final_with_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        final_fail |-> (done && !pass));
endmodule

bind bc_reply_check bcr_checker i_bcr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done       (done),
    .pass       (pass),
    .err_flags  (err_flags),
    .retry_req  (retry_req),
    .final_fail (final_fail)
);

// File: tb/test_bc_reply_check.sv
// Bench for the reply validator: a vector table walked by one loop, then
// directed tests for reset, timeouts, retries and ignored words.
module test_bc_reply_check;
    localparam int P   = 4;
    localparam int GAP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cfg_tmo_sel = '0;
    logic [5:0]  cfg_data_words = '0;
    logic [4:0]  cfg_rt_addr = 5'h0A;
    logic        cfg_rt2rt = 1'b0;
    logic [4:0]  cfg_rt_addr2 = 5'h13;
    logic [10:0] cfg_stat_mask = '0;
    logic        cfg_retry_en = 1'b0;
    logic        cfg_bus_switch = 1'b0;
    logic        cfg_cur_bus = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_stat_sync = 1'b0;
    logic [15:0] rx_word = '0;
    logic        rx_par = 1'b0;
    logic        rx_enc_err = 1'b0;
    logic        rx_len_err = 1'b0;
    logic        done, pass, retry_req, retry_bus, final_fail;
    logic [8:0]  err_flags;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int elapsed;

    always #4 clk = ~clk;

    bc_reply_check #(.CLK_PER_US(P), .GAP_US(GAP)) i_bc_reply_check (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_tmo_sel(cfg_tmo_sel),
        .cfg_data_words(cfg_data_words), .cfg_rt_addr(cfg_rt_addr),
        .cfg_rt2rt(cfg_rt2rt), .cfg_rt_addr2(cfg_rt_addr2),
        .cfg_stat_mask(cfg_stat_mask), .cfg_retry_en(cfg_retry_en),
        .cfg_bus_switch(cfg_bus_switch), .cfg_cur_bus(cfg_cur_bus),
        .rx_valid(rx_valid), .rx_stat_sync(rx_stat_sync), .rx_word(rx_word),
        .rx_par(rx_par), .rx_enc_err(rx_enc_err), .rx_len_err(rx_len_err),
        .done(done), .pass(pass), .err_flags(err_flags),
        .retry_req(retry_req), .retry_bus(retry_bus), .final_fail(final_fail)
    );

    // kind: 0 none, 1 flip sync, 2 coding strobe, 3 flip parity,
    // 4 bit-count strobe, 5 flip address bit 11, 6 set status bit 3
    typedef struct packed {
        logic [5:0]  n;
        logic [5:0]  send;
        logic [5:0]  bad;
        logic [2:0]  kind;
        logic [10:0] mask;
        logic        r2r;
        logic [8:0]  exp;
        logic [4:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{6'd3, 6'd4, 6'd63, 3'd0, 11'h000, 1'b0, 9'h000, 5'd13}, // R13 clean
        '{6'd0, 6'd1, 6'd63, 3'd0, 11'h000, 1'b0, 9'h000, 5'd7},  // R7 status only
        '{6'd3, 6'd4, 6'd2,  3'd1, 11'h000, 1'b0, 9'h002, 5'd4},  // R4 data sync
        '{6'd2, 6'd3, 6'd0,  3'd1, 11'h000, 1'b0, 9'h002, 5'd4},  // R4 status sync
        '{6'd2, 6'd3, 6'd1,  3'd2, 11'h000, 1'b0, 9'h004, 5'd5},  // R5
        '{6'd2, 6'd3, 6'd2,  3'd3, 11'h000, 1'b0, 9'h008, 5'd6},  // R6 parity
        '{6'd2, 6'd3, 6'd1,  3'd4, 11'h000, 1'b0, 9'h010, 5'd6},  // R6 bit count
        '{6'd4, 6'd3, 6'd63, 3'd0, 11'h000, 1'b0, 9'h020, 5'd7},  // R7 short
        '{6'd1, 6'd3, 6'd63, 3'd0, 11'h000, 1'b0, 9'h020, 5'd7},  // R7 long
        '{6'd2, 6'd3, 6'd0,  3'd5, 11'h000, 1'b0, 9'h040, 5'd8},  // R8
        '{6'd2, 6'd3, 6'd0,  3'd6, 11'h000, 1'b0, 9'h100, 5'd9},  // R9 unmasked
        '{6'd2, 6'd3, 6'd0,  3'd6, 11'h008, 1'b0, 9'h000, 5'd9},  // R9 masked
        '{6'd2, 6'd4, 6'd63, 3'd0, 11'h000, 1'b1, 9'h000, 5'd10}, // R10 clean
        '{6'd2, 6'd3, 6'd63, 3'd0, 11'h000, 1'b1, 9'h080, 5'd10}, // R10 missing
        '{6'd2, 6'd4, 6'd3,  3'd5, 11'h000, 1'b1, 9'h080, 5'd10}, // R10 address
        '{6'd2, 6'd4, 6'd3,  3'd1, 11'h000, 1'b1, 9'h080, 5'd10}, // R10 sync
        '{6'd2, 6'd2, 6'd63, 3'd0, 11'h000, 1'b1, 9'h0A0, 5'd10}, // R10 short
        '{6'd2, 6'd4, 6'd3,  3'd6, 11'h000, 1'b1, 9'h100, 5'd9}   // R9 second status
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one decoded word for one cycle, then leave a 2 us spacing.
    task automatic send_word(input logic s, input logic [15:0] d, input logic pf,
                             input logic e, input logic l);
        @(negedge clk);
        rx_valid = 1'b1; rx_stat_sync = s; rx_word = d;
        rx_par = (~^d) ^ pf; rx_enc_err = e; rx_len_err = l;
        @(negedge clk);
        rx_valid = 1'b0; rx_enc_err = 1'b0; rx_len_err = 1'b0;
        repeat (2 * P - 2) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Wait for done; elapsed counts negedges after the start pulse cleared.
    task automatic wait_done();
        for (int i = 0; i < 4000; i++) begin
            if (done) break;
            @(negedge clk);
            elapsed++;
        end
    endtask

    task automatic run_msg(input logic [5:0] n, input logic [5:0] send,
                           input logic [5:0] bad, input logic [2:0] kind,
                           input logic [10:0] mask, input logic r2r);
        cfg_data_words = n; cfg_rt2rt = r2r; cfg_stat_mask = mask;
        cfg_tmo_sel = 2'd0;
        pulse_start();
        repeat (2 * P - 1) @(negedge clk);
        for (int p = 0; p < int'(send); p++) begin
            logic        s;
            logic [15:0] d;
            logic        pf, e, l;
            pf = 1'b0; e = 1'b0; l = 1'b0;
            if (p == 0) begin
                s = 1'b1; d = {cfg_rt_addr, 11'h000};
            end else if (r2r && p == int'(n) + 1) begin
                s = 1'b1; d = {cfg_rt_addr2, 11'h000};
            end else begin
                s = 1'b0; d = 16'hA500 + 16'(p);
            end
            if (p == int'(bad)) begin
                case (kind)
                    3'd1: s = ~s;
                    3'd2: e = 1'b1;
                    3'd3: pf = 1'b1;
                    3'd4: l = 1'b1;
                    3'd5: d = d ^ 16'h0800;
                    3'd6: d = d | 16'h0008;
                    default: ;
                endcase
            end
            send_word(s, d, pf, e, l);
        end
        elapsed = 0;
        wait_done();
    endtask

    task automatic tmo_msg(input logic [1:0] sel, input int lim_us);
        cfg_tmo_sel = sel; cfg_data_words = 6'd0; cfg_rt2rt = 1'b0;
        pulse_start();
        elapsed = 0;
        wait_done();
        check("R2 timeout flags", int'(err_flags), 1);
        checks++;
        if (elapsed < lim_us * P - 2 || elapsed > lim_us * P + 2) begin
            errors++;
            $display("FAIL R2 sel %0d: actual=%0d cycles expected=%0d", sel, elapsed, lim_us * P);
        end
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=done", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: outputs during and after reset
        repeat (4) @(negedge clk);
        check("R1 during reset", int'({done, pass, err_flags, retry_req, final_fail, retry_bus}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 after reset", int'({done, pass, err_flags, retry_req, final_fail, retry_bus}), 0);

        for (int v = 0; v < NV; v++) begin
            run_msg(VECS[v].n, VECS[v].send, VECS[v].bad, VECS[v].kind,
                    VECS[v].mask, VECS[v].r2r);
            check($sformatf("R%0d vec %0d flags", VECS[v].req, v), int'(err_flags), int'(VECS[v].exp));
            check($sformatf("R%0d vec %0d pass", VECS[v].req, v), int'(pass), int'(VECS[v].exp == 9'h0));
            check($sformatf("R12 vec %0d verdict", v), int'({retry_req, final_fail}),
                  int'({1'b0, VECS[v].exp != 9'h0}));
        end

        // R13: done lasts one cycle, pass holds
        run_msg(6'd1, 6'd2, 6'd63, 3'd0, 11'h000, 1'b0);
        @(negedge clk);
        check("R13 done one cycle", int'({done, pass}), 1);

        // R13: a word while idle changes nothing (flags held from a failure)
        run_msg(6'd3, 6'd2, 6'd63, 3'd0, 11'h000, 1'b0);
        send_word(1'b0, 16'h1234, 1'b1, 1'b1, 1'b1);
        check("R13 idle word ignored", int'({done, pass, err_flags}), 9'h020);

        // R3: start clears flags the cycle after
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R3 clear on start", int'({pass, err_flags}), 0);
        elapsed = 0;
        wait_done();

        // R2: every select code, and a reply just inside the limit
        tmo_msg(2'd0, 18);
        tmo_msg(2'd1, 22);
        tmo_msg(2'd2, 50);
        tmo_msg(2'd3, 130);
        cfg_tmo_sel = 2'd0; cfg_data_words = 6'd0;
        pulse_start();
        repeat (16 * P) @(negedge clk);
        send_word(1'b1, {cfg_rt_addr, 11'h000}, 1'b0, 1'b0, 1'b0);
        elapsed = 0;
        wait_done();
        check("R2 reply inside limit", int'({pass, err_flags}), 10'h200);

        // R11 and R12: retry chain with channel switch
        cfg_retry_en = 1'b1; cfg_bus_switch = 1'b1; cfg_cur_bus = 1'b0;
        run_msg(6'd2, 6'd2, 6'd63, 3'd0, 11'h000, 1'b0);
        check("R11 first retry", int'({retry_req, final_fail, retry_bus}), 3'b101);
        cfg_cur_bus = 1'b1;
        run_msg(6'd2, 6'd2, 6'd63, 3'd0, 11'h000, 1'b0);
        check("R11 second retry", int'({retry_req, final_fail, retry_bus}), 3'b100);
        run_msg(6'd2, 6'd2, 6'd63, 3'd0, 11'h000, 1'b0);
        check("R12 budget spent", int'({retry_req, final_fail}), 2'b01);
        cfg_bus_switch = 1'b0;
        run_msg(6'd2, 6'd2, 6'd63, 3'd0, 11'h000, 1'b0);
        check("R12 fresh budget", int'({retry_req, final_fail, retry_bus}), 3'b101);
        run_msg(6'd2, 6'd3, 6'd63, 3'd0, 11'h000, 1'b0);
        check("R12 retry passes", int'({pass, retry_req, final_fail}), 3'b100);
        run_msg(6'd2, 6'd2, 6'd63, 3'd0, 11'h000, 1'b0);
        check("R12 budget after pass", int'({retry_req, final_fail}), 2'b10);
        cfg_retry_en = 1'b0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule